// File: doc/BRIEF.md
# Coprocessor Register Move Interlock Controller

This block moves one 32-bit word between a 64-bit general register port and the register space of an attached vector coprocessor. That register space is reached through memory-mapped addresses. A move is either a read, which loads a general register, or a write, which stores a general register's low word. Each move targets one of two address classes: the control registers or the data register window. It names a register id and carries an interlock bit.

Before the bus access starts, the block holds the issuing pipeline until the coprocessor's state allows the move. When the coprocessor is busy in macro mode, the move waits on the hazard flag for the targeted id, and the interlock bit only raises a warning. When the coprocessor is busy in micro mode, the interlock bit decides whether the move waits at all. A read waits for micro-mode busy to drop. A write waits for the coprocessor's interlock release signal.

Once the move is released, the block forms the word address as the class base plus sixteen times the id. It then performs a single handshaked bus transfer and, for reads, returns the sign-extended word for register writeback.

Top module: `cpr_move_unit`

## Requirements
- R1: After reset the block is idle: `stallOut`, `busValid`, `wbValid` and `warnOut` are all low.
- R2: A request (`reqValid` high) is accepted only when the block is idle. A request presented during a move in progress is ignored and causes no second bus transfer.
- R3: While `macroBusy` is high, a move waits as long as `macroHazard[id]` is high for its own id, whatever its interlock bit. Hazard bits of other ids do not hold it. Macro mode takes priority over micro mode.
- R4: A move evaluated while `macroBusy` is high with its interlock bit set pulses `warnOut` for one cycle when the move completes. The interlock bit does not change its wait.
- R5: A read with the interlock bit set waits while `microBusy` is high (and `macroBusy` is low). `microRelease` has no effect on a read.
- R6: A write with the interlock bit set waits while `microBusy` is high until `microRelease` is high, even if `microBusy` stays high.
- R7: With the interlock bit clear and `macroBusy` low, a move does not wait. `busValid` rises in the second cycle after the accepting edge.
- R8: The bus address is `WIN_BASE + id*16` when `reqWindow`=1 and `CTRL_BASE + id*16` when `reqWindow`=0. Its low four bits are zero.
- R9: Once `busValid` is high, it stays high with `busAddr`, `busWrite` and `busWdata` unchanged until a cycle with `busReady` high.
- R10: For a read, `wbValid` is high for exactly one cycle after the accepting transfer. `wbData` is `busRdata` sign-extended from bit 31 to 64 bits, and `wbRt` equals the request's `reqRt`.
- R11: A write drives `busWrite`=1 and `busWdata` = bits 31:0 of `reqData`, and never raises `wbValid`.
- R12: `stallOut` is high from the cycle after acceptance through the cycle in which `busReady` is seen, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Move request strobe |
| reqWrite | input | 1 | 1 = write to coprocessor, 0 = read |
| reqWindow | input | 1 | 1 = register window class, 0 = control class |
| reqId | input | ID_W | Coprocessor register id |
| reqRt | input | RT_W | General register index for writeback |
| reqData | input | 64 | General register value for a write |
| reqInterlock | input | 1 | Interlock bit of the move |
| macroBusy | input | 1 | Coprocessor busy in macro mode |
| microBusy | input | 1 | Coprocessor busy in micro mode |
| macroHazard | input | 2**ID_W | Per-id macro hazard flags |
| microRelease | input | 1 | Micro-mode interlock released |
| stallOut | output | 1 | Hold the issuing pipeline |
| warnOut | output | 1 | Interlock bit used in macro mode |
| busValid | output | 1 | Bus transfer request |
| busWrite | output | 1 | Bus transfer direction |
| busAddr | output | ADDR_W | Bus word address |
| busWdata | output | 32 | Bus write data |
| busReady | input | 1 | Bus transfer completion |
| busRdata | input | 32 | Bus read data |
| wbValid | output | 1 | Writeback strobe for reads |
| wbRt | output | RT_W | Writeback register index |
| wbData | output | 64 | Sign-extended read data |

## Verification
The bench aims at the asymmetric release rules. A read is held on `microBusy` while `microRelease` toggles high, which would catch a design that released reads on the write condition. A write is held with `microBusy` stuck high until `microRelease` rises, which catches a design that used the read condition for writes. In macro mode, a hazard on a different id must not stall a move, and a set interlock bit must neither add a wait nor fail to raise the warning. This exposes a design that decoded the wrong hazard bit or let the interlock bit leak into macro mode. The bench also uses a negative read word to catch zero extension, and injects a request during a bus wait to catch a design that restarts or re-addresses the transfer.

// File: rtl/cpr_move_pkg.sv
package cpr_move_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STALL  = 2'd1,
    ST_ACCESS = 2'd2,
    ST_DONE   = 2'd3
  } moveState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic capReq;    // latch the request fields
    logic capRdata;  // latch bus read data
    logic markWarn;  // interlock bit seen in macro mode
  } dpCtl_t;

endpackage

// File: rtl/cpr_move_ctrl.sv
module cpr_move_ctrl
  import cpr_move_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   macroBusy,
  input  logic   microBusy,
  input  logic   microRelease,
  input  logic   busReady,
  input  logic   hazardSel,
  input  logic   isWrite,
  input  logic   ilFlag,
  input  logic   warnFlag,
  output dpCtl_t dpCtl,
  output logic   stallOut,
  output logic   busValid,
  output logic   wbValid,
  output logic   warnOut
);

  moveState_t state, stateNext;
  logic holdNow;

  // Wait condition: macro mode dominates; micro mode waits only with interlock
  always_comb begin
    if (macroBusy) begin
      holdNow = hazardSel;
    end else if (microBusy && ilFlag) begin
      holdNow = isWrite ? !microRelease : 1'b1;
    end else begin
      holdNow = 1'b0;
    end
  end

  always_comb begin
    stateNext = state;
    dpCtl     = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          dpCtl.capReq = 1'b1;
          stateNext    = ST_STALL;
        end
      end
      ST_STALL: begin
        dpCtl.markWarn = macroBusy && ilFlag;
        if (!holdNow) stateNext = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (busReady) begin
          dpCtl.capRdata = 1'b1;
          stateNext      = ST_DONE;
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign stallOut = (state == ST_STALL) || (state == ST_ACCESS);
  assign busValid = (state == ST_ACCESS);
  assign wbValid  = (state == ST_DONE) && !isWrite;
  assign warnOut  = (state == ST_DONE) && warnFlag;

endmodule

// File: rtl/cpr_move_dp.sv
module cpr_move_dp
  import cpr_move_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 5,
  parameter int RT_W   = 5,
  parameter int GPR_W  = 64,
  parameter int WORD_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h1100_4000
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             dpCtl,
  input  logic               reqWrite,
  input  logic               reqWindow,
  input  logic [ID_W-1:0]    reqId,
  input  logic [RT_W-1:0]    reqRt,
  input  logic [GPR_W-1:0]   reqData,
  input  logic               reqInterlock,
  input  logic [(1<<ID_W)-1:0] macroHazard,
  input  logic [WORD_W-1:0]  busRdata,
  output logic               hazardSel,
  output logic               isWrite,
  output logic               ilFlag,
  output logic               warnFlag,
  output logic [ADDR_W-1:0]  busAddr,
  output logic               busWrite,
  output logic [WORD_W-1:0]  busWdata,
  output logic [RT_W-1:0]    wbRt,
  output logic [GPR_W-1:0]   wbData
);

  localparam int STRIDE_SH = 4;               // 16-byte register stride
  localparam int PAD_W     = ADDR_W - ID_W - STRIDE_SH;
  localparam int EXT_W     = GPR_W - WORD_W;

  logic                writeR, windowR, ilR, warnR;
  logic [ID_W-1:0]     idR;
  logic [RT_W-1:0]     rtR;
  logic [WORD_W-1:0]   wdataR, rdataR;
  logic [ADDR_W-1:0]   baseSel, offset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      writeR  <= 1'b0;
      windowR <= 1'b0;
      ilR     <= 1'b0;
      idR     <= '0;
      rtR     <= '0;
      wdataR  <= '0;
    end else if (dpCtl.capReq) begin
      writeR  <= reqWrite;
      windowR <= reqWindow;
      ilR     <= reqInterlock;
      idR     <= reqId;
      rtR     <= reqRt;
      wdataR  <= reqData[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdataR <= '0;
    else if (dpCtl.capRdata) rdataR <= busRdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warnR <= 1'b0;
    else if (dpCtl.capReq)   warnR <= 1'b0;
    else if (dpCtl.markWarn) warnR <= 1'b1;
  end

  assign baseSel  = windowR ? WIN_BASE : CTRL_BASE;
  assign offset   = {{PAD_W{1'b0}}, idR, {STRIDE_SH{1'b0}}};
  assign busAddr  = baseSel + offset;
  assign busWrite = writeR;
  assign busWdata = wdataR;

  assign hazardSel = macroHazard[idR];
  assign isWrite   = writeR;
  assign ilFlag    = ilR;
  assign warnFlag  = warnR;

  assign wbRt   = rtR;
  assign wbData = {{EXT_W{rdataR[WORD_W-1]}}, rdataR};

endmodule

// File: rtl/cpr_move_unit.sv
module cpr_move_unit
  import cpr_move_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 5,
  parameter int RT_W   = 5,
  parameter logic [ADDR_W-1:0] CTRL_BASE = 32'h1000_0000,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 32'h1100_4000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqWindow,
  input  logic [ID_W-1:0]      reqId,
  input  logic [RT_W-1:0]      reqRt,
  input  logic [63:0]          reqData,
  input  logic                 reqInterlock,
  input  logic                 macroBusy,
  input  logic                 microBusy,
  input  logic [(1<<ID_W)-1:0] macroHazard,
  input  logic                 microRelease,
  output logic                 stallOut,
  output logic                 warnOut,
  output logic                 busValid,
  output logic                 busWrite,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [31:0]          busWdata,
  input  logic                 busReady,
  input  logic [31:0]          busRdata,
  output logic                 wbValid,
  output logic [RT_W-1:0]      wbRt,
  output logic [63:0]          wbData
);

  dpCtl_t dpCtl;
  logic   hazardSel, isWrite, ilFlag, warnFlag;

  cpr_move_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .macroBusy    (macroBusy),
    .microBusy    (microBusy),
    .microRelease (microRelease),
    .busReady     (busReady),
    .hazardSel    (hazardSel),
    .isWrite      (isWrite),
    .ilFlag       (ilFlag),
    .warnFlag     (warnFlag),
    .dpCtl        (dpCtl),
    .stallOut     (stallOut),
    .busValid     (busValid),
    .wbValid      (wbValid),
    .warnOut      (warnOut)
  );

  cpr_move_dp #(
    .ADDR_W    (ADDR_W),
    .ID_W      (ID_W),
    .RT_W      (RT_W),
    .GPR_W     (64),
    .WORD_W    (32),
    .CTRL_BASE (CTRL_BASE),
    .WIN_BASE  (WIN_BASE)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .dpCtl        (dpCtl),
    .reqWrite     (reqWrite),
    .reqWindow    (reqWindow),
    .reqId        (reqId),
    .reqRt        (reqRt),
    .reqData      (reqData),
    .reqInterlock (reqInterlock),
    .macroHazard  (macroHazard),
    .busRdata     (busRdata),
    .hazardSel    (hazardSel),
    .isWrite      (isWrite),
    .ilFlag       (ilFlag),
    .warnFlag     (warnFlag),
    .busAddr      (busAddr),
    .busWrite     (busWrite),
    .busWdata     (busWdata),
    .wbRt         (wbRt),
    .wbData       (wbData)
  );

endmodule

// File: rtl/cpr_move_chk.sv
module cpr_move_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              stallOut,
  input logic              warnOut,
  input logic              busValid,
  input logic              busReady,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              wbValid
);

  AST_IDLE_AT_RESET: assert property (@(posedge clk) !rstN |-> !busValid && !wbValid) else $error("idle at reset"); // R1

  AST_ACCEPT_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stallOut) |-> $past(reqValid)) else $error("stall without request"); // R2

  AST_WARN_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    warnOut |-> !stallOut && !busValid) else $error("warn outside completion"); // R4

  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    busValid |-> busAddr[3:0] == 4'h0) else $error("misaligned address"); // R8

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busReady |=> busValid && $stable(busAddr) && $stable(busWdata) && $stable(busWrite))
    else $error("bus request dropped or changed"); // R9

  AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |=> !wbValid) else $error("writeback longer than one cycle"); // R10

  AST_WB_NOT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> !busWrite) else $error("writeback on a write"); // R11

  AST_STALL_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    busValid && busReady |=> !stallOut) else $error("stall after completion"); // R12

endmodule

bind cpr_move_unit cpr_move_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .stallOut (stallOut),
  .warnOut  (warnOut),
  .busValid (busValid),
  .busReady (busReady),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .wbValid  (wbValid)
);

// File: tb/cpr_move_unit_bench.sv
module cpr_move_unit_bench;

  localparam logic [31:0] CB = 32'h1000_0000;
  localparam logic [31:0] WB = 32'h1100_4000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 0, reqWrite = 0, reqWindow = 0, reqInterlock = 0;
  logic [4:0]  reqId = 0, reqRt = 0;
  logic [63:0] reqData = 0;
  logic        macroBusy = 0, microBusy = 0, microRelease = 0;
  logic [31:0] macroHazard = 0;
  logic        busReady = 0;
  logic [31:0] busRdata = 0;
  logic        stallOut, warnOut, busValid, busWrite, wbValid;
  logic [31:0] busAddr, busWdata;
  logic [4:0]  wbRt;
  logic [63:0] wbData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  cpr_move_unit #(.CTRL_BASE(CB), .WIN_BASE(WB)) u_cpr_move_unit (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqWindow(reqWindow), .reqId(reqId), .reqRt(reqRt), .reqData(reqData),
    .reqInterlock(reqInterlock), .macroBusy(macroBusy), .microBusy(microBusy),
    .macroHazard(macroHazard), .microRelease(microRelease), .stallOut(stallOut),
    .warnOut(warnOut), .busValid(busValid), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busReady(busReady), .busRdata(busRdata),
    .wbValid(wbValid), .wbRt(wbRt), .wbData(wbData)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ceq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    check(act === exp, tag, act, exp);
  endtask

  // Present one request for one cycle; returns at the negedge after acceptance
  task automatic issue(input bit wr, input bit win, input logic [4:0] id,
                       input logic [4:0] rt, input logic [63:0] d, input bit il);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqWindow = win; reqId = id; reqRt = rt;
    reqData = d; reqInterlock = il;
    @(negedge clk);
    reqValid = 0;
    ceq("R12 stall after accept", stallOut, 1);
    ceq("R12 no bus in wait state", busValid, 0);
  endtask

  // Called at a negedge where busValid is expected high
  task automatic serve(input string tag, input logic [31:0] expAddr, input bit wr,
                       input logic [31:0] expW, input logic [31:0] rd,
                       input int holds, input bit expWarn, input logic [4:0] rt);
    ceq({tag, " busValid"}, busValid, 1);
    ceq({tag, " R8 address"}, busAddr, expAddr);
    ceq({tag, " busWrite"}, busWrite, wr);
    if (wr) ceq({tag, " R11 wdata"}, busWdata, expW);
    for (int i = 0; i < holds; i++) begin
      @(negedge clk);
      ceq({tag, " R9 valid held"}, busValid, 1);
      ceq({tag, " R9 addr held"}, busAddr, expAddr);
      ceq({tag, " R12 stall during access"}, stallOut, 1);
    end
    busRdata = rd;
    busReady = 1;
    @(negedge clk);
    busReady = 0;
    ceq({tag, " R12 stall released"}, stallOut, 0);
    ceq({tag, " R10 R11 wbValid"}, wbValid, !wr);
    ceq({tag, " R4 warn"}, warnOut, expWarn);
    if (!wr) begin
      ceq({tag, " R10 sign extension"}, wbData, {{32{rd[31]}}, rd});
      ceq({tag, " R10 wbRt"}, wbRt, rt);
    end
    @(negedge clk);
    ceq({tag, " R10 single wb"}, wbValid, 0);
    ceq({tag, " R4 single warn"}, warnOut, 0);
  endtask

  task automatic t_reset;
    ceq("R1 stall at reset", stallOut, 0);
    ceq("R1 busValid at reset", busValid, 0);
    ceq("R1 wbValid at reset", wbValid, 0);
    ceq("R1 warn at reset", warnOut, 0);
  endtask

  task automatic t_micro_noil;
    microBusy = 1; microRelease = 0;
    issue(1, 0, 5'd3, 5'd0, 64'hDEAD_BEEF_0123_4567, 0);
    @(negedge clk);
    ceq("R7 no wait", busValid, 1);
    serve("R7 R11 write", CB + 32'h30, 1, 32'h0123_4567, 32'h0, 2, 0, 5'd0);
    microBusy = 0;
  endtask

  task automatic t_macro_hazard;
    macroBusy = 1; macroHazard = 32'h0000_0080; microRelease = 1;
    issue(0, 1, 5'd7, 5'd12, 64'h0, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      ceq("R3 held by own hazard", busValid, 0);
      ceq("R3 stall held", stallOut, 1);
    end
    macroHazard = 0;
    @(negedge clk);
    ceq("R3 released", busValid, 1);
    serve("R3 R4 macro read", WB + 32'h70, 0, 0, 32'h8000_0001, 0, 1, 5'd12);
    macroHazard = 32'h0000_0004;
    microBusy = 1;
    issue(0, 0, 5'd5, 5'd2, 64'h0, 0);
    @(negedge clk);
    ceq("R3 other id hazard ignored", busValid, 1);
    serve("R3 macro other id", CB + 32'h50, 0, 0, 32'h7FFF_FFFF, 0, 0, 5'd2);
    macroBusy = 0; microBusy = 0; macroHazard = 0; microRelease = 0;
  endtask

  task automatic t_read_micro;
    microBusy = 1; microRelease = 1;
    issue(0, 0, 5'd1, 5'd31, 64'h0, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ceq("R5 read waits on busy", busValid, 0);
    end
    microBusy = 0;
    @(negedge clk);
    ceq("R5 read released", busValid, 1);
    serve("R5 read", CB + 32'h10, 0, 0, 32'h1234_5678, 1, 0, 5'd31);
    microRelease = 0;
  endtask

  task automatic t_write_micro;
    microBusy = 1; microRelease = 0;
    issue(1, 1, 5'd31, 5'd0, 64'h5555_AAAA_F00D_CAFE, 1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      ceq("R6 write waits on release", busValid, 0);
    end
    microRelease = 1;
    @(negedge clk);
    ceq("R6 write released while busy", busValid, 1);
    serve("R6 write", WB + 32'h1F0, 1, 32'hF00D_CAFE, 0, 0, 0, 5'd0);
    microBusy = 0; microRelease = 0;
  endtask

  task automatic t_ignore;
    issue(0, 1, 5'd2, 5'd4, 64'h0, 0);
    @(negedge clk);
    ceq("R2 first access", busAddr, WB + 32'h20);
    reqValid = 1; reqId = 5'd9; reqWindow = 0; reqWrite = 1;
    @(negedge clk);
    ceq("R2 address kept", busAddr, WB + 32'h20);
    ceq("R2 direction kept", busWrite, 0);
    busRdata = 32'hFFFF_0000; busReady = 1;
    @(negedge clk);
    busReady = 0; reqValid = 0;
    ceq("R2 completed read", wbData, 64'hFFFF_FFFF_FFFF_0000);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ceq("R2 no second access", busValid, 0);
      ceq("R2 no stall", stallOut, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_micro_noil();
    t_macro_hazard();
    t_read_micro();
    t_write_micro();
    t_ignore();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule